// File: doc/BRIEF.md
# Three-Channel Capture/Waveform Timer Counter

This block holds three independent 16-bit timer/counter channels. Each channel has two I/O lines, A and B. Each one counts on a clock that it picks from eight sources. Five of them are fixed taps of the master clock, at divide-by 2, 8, 32, 128 and 1024. The other three are external clock pins. An external pin is synchronized to the master clock first, and only its rising edges are counted. A channel is stopped after reset. A per-channel trigger, or a block-wide synchronization pulse, clears its counter to zero and sets it running. The block-wide pulse restarts all three channels in the same cycle.

A channel runs in one of two modes. In capture mode the counter runs freely and wraps. A selected edge on input line A stores the current count, first in capture register A, then in capture register B, and so on in turn. A full flag tracks each capture register until a read strobe clears it. Storing into a register that is still full raises a sticky overrun flag. In waveform mode register C bounds the count. The count runs either upward, restarting after C, or up to C and back down to 0. Matches on registers A, B and C set, clear or toggle output lines A and B.

Configuration, compare values and read or clear strobes arrive as plain ports. An outer register file is expected to drive them.

Top module: `tcc_block`

## Requirements
- R1: After reset every count, capture register, flag and output line is 0. A channel's counter stays at 0 until its first trigger or synchronization pulse.
- R2: Clock-select codes 0, 1, 2, 3 and 4 advance the counter once every 2, 8, 32, 128 and 1024 master clock cycles. These taps run freely from reset, so any window whose length is a multiple of the divisor holds exactly window/divisor advances.
- R3: Codes 5, 6 and 7 pick external pins 0, 1 and 2. A rising edge on the selected pin advances the counter at the third rising master-clock edge after the pin goes high. Edges on pins that are not selected have no effect.
- R4: `trig[i]` clears channel i's counter to 0 at the next edge and starts it. `glb_sync` does the same to every channel. A trigger on one channel leaves the other channels counting.
- R5: `ovf[i]` sets when the counter moves from all-ones to 0. It stays set until `flag_clr[i]`.
- R6: In capture mode, `cap_edge` picks the edge of input line A that captures the count: 0 picks rising, 1 picks falling, and 2 or 3 pick both. Edges that are not selected capture nothing. The stored value is the count present at the clock edge where the line change is first seen.
- R7: Captures alternate between register A and register B, starting with A after a trigger. Each capture sets that register's full flag. `rd_a` and `rd_b` clear the flags.
- R8: A capture into a register whose full flag is set still stores the value and also sets `ovr[i]`. `ovr[i]` stays set until `flag_clr[i]`.
- R9: In waveform up mode (`updown`=0) the counter runs 0, 1, …, C and then returns to 0, so one period is C+1 counts.
- R10: In waveform up/down mode (`updown`=1, C ≥ 1) the counter runs up from 0 to C and then down to 0, so one period is 2·C counts.
- R11: Action codes are 0 none, 1 set, 2 clear and 3 toggle. They apply on the count step that leaves a matching value. A match on A acts on line A (`act_am`), and a match on B acts on line B (`act_bm`). A match on C acts on line A (`act_ca`) and on line B (`act_cb`). When A and C match together, a non-zero C action decides line A.
- R12: In capture mode both output lines are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 3 | External clock pins |
| glb_sync | input | 1 | Restart all channels |
| trig | input | NCH | Per-channel restart |
| sel_clk | input | NCH×3 | Clock source code per channel |
| wave_mode | input | NCH | 1 = waveform, 0 = capture |
| updown | input | NCH | Waveform up/down counting |
| cap_edge | input | NCH×2 | Capture edge selection |
| cmp_a | input | NCH×W | Compare value A |
| cmp_b | input | NCH×W | Compare value B |
| cmp_c | input | NCH×W | Compare value C (period bound) |
| act_am | input | NCH×2 | Line A action on A match |
| act_bm | input | NCH×2 | Line B action on B match |
| act_ca | input | NCH×2 | Line A action on C match |
| act_cb | input | NCH×2 | Line B action on C match |
| line_a_in | input | NCH | Input line A (capture source) |
| rd_a | input | NCH | Read strobe, capture register A |
| rd_b | input | NCH | Read strobe, capture register B |
| flag_clr | input | NCH | Clears overrun and overflow |
| count | output | NCH×W | Counter values |
| cap_ra | output | NCH×W | Capture register A |
| cap_rb | output | NCH×W | Capture register B |
| ra_full | output | NCH | Capture A holds an unread value |
| rb_full | output | NCH | Capture B holds an unread value |
| ovr | output | NCH | Capture overrun flag |
| ovf | output | NCH | Counter wrap flag |
| line_a_out | output | NCH | Output line A |
| line_b_out | output | NCH | Output line B |

## Verification
A table drives each internal divider code through a window sized to a multiple of its divisor. An exact advance count therefore separates the five taps from one another. External-pin tests pulse the selected pin and then an unselected pin. This separates a correct source and synchronizer latency from a wrong mux index or a short synchronizer. Capture sequences of rising, falling and mixed edges show whether edges are selected, whether registers A and B alternate, and when overrun arises. Waveform runs in up mode, up/down mode and with a coincident A/C match use duty counts over whole periods. These counts expose wrong period bounds, wrong turn-around points and a wrong action priority.

// File: rtl/tcc_pkg.sv
// Shared constants, action encoding and helpers for the timer/counter block.
package tcc_pkg;
    localparam int NTAP = 5;                     // internal divider taps
    localparam int NEXT = 3;                     // external clock pins
    localparam int NSRC = NTAP + NEXT;           // total clock sources
    localparam int SELW = $clog2(NSRC);          // clock select width

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    // log2 of the divisor for internal tap k: 2, 8, 32, 128, 1024
    function automatic int tap_shift(input int k);
        case (k)
            0:       return 1;
            1:       return 3;
            2:       return 5;
            3:       return 7;
            default: return 10;
        endcase
    endfunction

    // New level of an output line after applying an action code
    function automatic logic apply_act(input logic cur, input logic [1:0] a);
        case (act_e'(a))
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/tcc_prescale.sv
// Free-running master-clock prescaler. Produces one single-cycle enable per
// internal tap; tap k pulses once every 2**tap_shift(k) cycles.
// Assumes PW >= the largest tap shift.
module tcc_prescale import tcc_pkg::*; #(
    parameter int PW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NTAP-1:0] tap_tick
);
    logic [PW-1:0] pre;

    // free-running divider count
    always_ff @(posedge clk) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        localparam int SH = tap_shift(k);
        assign tap_tick[k] = &pre[SH-1:0];
    end
endmodule

// File: rtl/tcc_edge_sync.sv
// Two-stage synchronizer plus rising-edge detector for asynchronous clock
// pins. rise[n] is a one-cycle pulse two edges after pin[n] is first sampled high.
module tcc_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1, s2, s3;

    // synchronizer chain and previous-value stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0; s2 <= '0; s3 <= '0;
        end else begin
            s1 <= pin; s2 <= s1; s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/tcc_channel.sv
// One timer/counter channel: counter with restart, capture of the count on
// edges of input line A, and compare-driven output lines in waveform mode.
// Assumes line_in is synchronous to clk and cmp_c >= 1 in up/down mode.
module tcc_channel import tcc_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic         wave,
    input  logic         updown,
    input  logic [1:0]   cap_edge,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] rc,
    input  logic [1:0]   act_am,
    input  logic [1:0]   act_bm,
    input  logic [1:0]   act_ca,
    input  logic [1:0]   act_cb,
    input  logic         line_in,
    input  logic         rd_a,
    input  logic         rd_b,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         a_full,
    output logic         b_full,
    output logic         ovr,
    output logic         ovf,
    output logic         out_a,
    output logic         out_b
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         running, dir_up, dir_nxt, sel_b, lin_q;
    logic [W-1:0] cnt_nxt;
    logic         go, ovf_set, hit, cap_ev, ovr_set;
    logic         oa_nxt, ob_nxt;

    assign go = running & tick & ~restart;

    // next count and direction for the active mode
    always_comb begin
        cnt_nxt = cnt + 1'b1;
        dir_nxt = dir_up;
        if (wave) begin
            if (!updown) begin
                if (cnt == rc) cnt_nxt = '0;
            end else if (dir_up) begin
                if (cnt >= rc) begin
                    cnt_nxt = cnt - 1'b1;
                    dir_nxt = 1'b0;
                end
            end else begin
                if (cnt == '0) dir_nxt = 1'b1;
                else           cnt_nxt = cnt - 1'b1;
            end
        end
    end

    assign ovf_set = go && (cnt == MAXV) && (cnt_nxt == '0);

    // counter, direction and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; dir_up <= 1'b1; running <= 1'b0;
        end else if (restart) begin
            cnt <= '0; dir_up <= 1'b1; running <= 1'b1;
        end else if (go) begin
            cnt <= cnt_nxt; dir_up <= dir_nxt;
        end
    end

    // sticky overflow flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= ovf_set | (ovf & ~flag_clr);
    end

    // compare actions; a non-zero C action takes precedence
    always_comb begin
        oa_nxt = out_a;
        ob_nxt = out_b;
        if (go) begin
            if (cnt == rc && act_ca != 2'd0) oa_nxt = apply_act(out_a, act_ca);
            else if (cnt == ra)              oa_nxt = apply_act(out_a, act_am);
            if (cnt == rc && act_cb != 2'd0) ob_nxt = apply_act(out_b, act_cb);
            else if (cnt == rb)              ob_nxt = apply_act(out_b, act_bm);
        end
    end

    // output lines, held low outside waveform mode
    always_ff @(posedge clk) begin
        if (!rst_n || !wave) begin
            out_a <= 1'b0; out_b <= 1'b0;
        end else begin
            out_a <= oa_nxt; out_b <= ob_nxt;
        end
    end

    // capture edge selection on line A
    always_comb begin
        case (cap_edge)
            2'd0:    hit = line_in & ~lin_q;
            2'd1:    hit = ~line_in & lin_q;
            default: hit = line_in ^ lin_q;
        endcase
    end

    assign cap_ev  = ~wave & hit;
    assign ovr_set = cap_ev & (sel_b ? b_full : a_full);

    // capture registers, alternation and full flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q <= 1'b0; sel_b <= 1'b0;
            cap_a <= '0; cap_b <= '0;
            a_full <= 1'b0; b_full <= 1'b0; ovr <= 1'b0;
        end else begin
            lin_q <= line_in;
            ovr   <= ovr_set | (ovr & ~flag_clr);
            if (rd_a) a_full <= 1'b0;
            if (rd_b) b_full <= 1'b0;
            if (restart) begin
                sel_b <= 1'b0;
            end else if (cap_ev) begin
                sel_b <= ~sel_b;
                if (sel_b) begin cap_b <= cnt; b_full <= 1'b1; end
                else       begin cap_a <= cnt; a_full <= 1'b1; end
            end
        end
    end
endmodule

// File: rtl/tcc_block.sv
// Three-channel timer/counter wrapper: shared prescaler and external-clock
// synchronizer, per-channel clock source mux, block-wide restart pulse.
// Assumes all control inputs are synchronous to clk except ext_clk.
module tcc_block import tcc_pkg::*; #(
    parameter int NCH = 3,
    parameter int W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NEXT-1:0]           ext_clk,
    input  logic                      glb_sync,
    input  logic [NCH-1:0]            trig,
    input  logic [NCH-1:0][SELW-1:0]  sel_clk,
    input  logic [NCH-1:0]            wave_mode,
    input  logic [NCH-1:0]            updown,
    input  logic [NCH-1:0][1:0]       cap_edge,
    input  logic [NCH-1:0][W-1:0]     cmp_a,
    input  logic [NCH-1:0][W-1:0]     cmp_b,
    input  logic [NCH-1:0][W-1:0]     cmp_c,
    input  logic [NCH-1:0][1:0]       act_am,
    input  logic [NCH-1:0][1:0]       act_bm,
    input  logic [NCH-1:0][1:0]       act_ca,
    input  logic [NCH-1:0][1:0]       act_cb,
    input  logic [NCH-1:0]            line_a_in,
    input  logic [NCH-1:0]            rd_a,
    input  logic [NCH-1:0]            rd_b,
    input  logic [NCH-1:0]            flag_clr,
    output logic [NCH-1:0][W-1:0]     count,
    output logic [NCH-1:0][W-1:0]     cap_ra,
    output logic [NCH-1:0][W-1:0]     cap_rb,
    output logic [NCH-1:0]            ra_full,
    output logic [NCH-1:0]            rb_full,
    output logic [NCH-1:0]            ovr,
    output logic [NCH-1:0]            ovf,
    output logic [NCH-1:0]            line_a_out,
    output logic [NCH-1:0]            line_b_out
);
    localparam int PW = tap_shift(NTAP - 1);

    logic [NTAP-1:0] tap_tick;
    logic [NEXT-1:0] ext_rise;
    logic [NSRC-1:0] src;

    tcc_prescale #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .tap_tick(tap_tick)
    );

    tcc_edge_sync #(.N(NEXT)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise)
    );

    assign src = {ext_rise, tap_tick};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic tick_i;
        assign tick_i = src[sel_clk[i]];

        tcc_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_i),
            .restart(trig[i] | glb_sync),
            .wave(wave_mode[i]), .updown(updown[i]), .cap_edge(cap_edge[i]),
            .ra(cmp_a[i]), .rb(cmp_b[i]), .rc(cmp_c[i]),
            .act_am(act_am[i]), .act_bm(act_bm[i]),
            .act_ca(act_ca[i]), .act_cb(act_cb[i]),
            .line_in(line_a_in[i]), .rd_a(rd_a[i]), .rd_b(rd_b[i]),
            .flag_clr(flag_clr[i]),
            .cnt(count[i]), .cap_a(cap_ra[i]), .cap_b(cap_rb[i]),
            .a_full(ra_full[i]), .b_full(rb_full[i]),
            .ovr(ovr[i]), .ovf(ovf[i]),
            .out_a(line_a_out[i]), .out_b(line_b_out[i])
        );
    end
endmodule

// File: rtl/tcc_block_chk.sv
// Property checker for tcc_block, attached by bind. Observes ports only.
module tcc_block_chk #(
    parameter int NCH = 3,
    parameter int W   = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  glb_sync,
    input logic [NCH-1:0]        trig,
    input logic [NCH-1:0]        wave_mode,
    input logic [NCH-1:0]        updown,
    input logic [NCH-1:0][W-1:0] cmp_c,
    input logic [NCH-1:0][W-1:0] count,
    input logic [NCH-1:0]        ovf,
    input logic [NCH-1:0]        ovr,
    input logic [NCH-1:0]        ra_full,
    input logic [NCH-1:0]        rb_full,
    input logic [NCH-1:0]        line_a_out,
    input logic [NCH-1:0]        line_b_out
);
    for (genvar i = 0; i < NCH; i++) begin : g_p
        a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] || glb_sync) |=> (count[i] == '0));

        a_r5_ovf_from_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf[i]) |-> ($past(count[i]) == {W{1'b1}}));

        a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr[i]) |-> $past(ra_full[i] || rb_full[i]));

        a_r12_capture_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
            !wave_mode[i] |=> (!line_a_out[i] && !line_b_out[i]));

        a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && !glb_sync && !wave_mode[i])
            |=> (W'(count[i] - $past(count[i])) <= W'(1)));

        a_r9_wrap_after_c: assert property (@(posedge clk) disable iff (!rst_n)
            (wave_mode[i] && !updown[i] && !trig[i] && !glb_sync && count[i] == cmp_c[i])
            |=> (count[i] == $past(cmp_c[i]) || count[i] == '0));
    end
endmodule

bind tcc_block tcc_block_chk #(.NCH(NCH), .W(W)) u_chk (.*);

// File: tb/sim_tcc_block.sv
// Self-checking bench for tcc_block: table-driven divider check, then
// directed tests for external clocks, restart, overflow, capture, waveforms.
module sim_tcc_block;
    localparam int NCH = 3;
    localparam int W   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ext_clk = '0;
    logic glb_sync = 1'b0;
    logic [NCH-1:0] trig = '0, wave_mode = '0, updown = '0;
    logic [NCH-1:0][2:0] sel_clk = '0;
    logic [NCH-1:0][1:0] cap_edge = '0, act_am = '0, act_bm = '0, act_ca = '0, act_cb = '0;
    logic [NCH-1:0][W-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0;
    logic [NCH-1:0] line_a_in = '0, rd_a = '0, rd_b = '0, flag_clr = '0;
    logic [NCH-1:0][W-1:0] count, cap_ra, cap_rb;
    logic [NCH-1:0] ra_full, rb_full, ovr, ovf, line_a_out, line_b_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tcc_block #(.NCH(NCH), .W(W)) u0 (.*);

    // {clock code, window cycles, expected advances}
    localparam int TBL[5][3] = '{'{0, 40, 20}, '{1, 80, 10}, '{2, 128, 4},
                                 '{3, 256, 2}, '{4, 2048, 2}};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(input int ch);
        trig[ch] = 1'b1; cyc(1); trig[ch] = 1'b0;
    endtask

    // set line A of channel 0; returns count seen at the capturing edge
    task automatic drive_line(input logic v, output int c);
        c = int'(count[0]); line_a_in[0] = v; cyc(1);
    endtask

    // run a waveform window, counting high cycles and count extremes
    task automatic wave_window(input int n, output int hia, output int hib,
                               output int maxc, output int minc, output int bad_step,
                               output int bad_rel);
        int prev;
        hia = 0; hib = 0; maxc = 0; minc = 1 << W; bad_step = 0; bad_rel = 0;
        prev = int'(count[0]);
        for (int k = 0; k < n; k++) begin
            int c;
            c = int'(count[0]);
            if (line_a_out[0]) hia++;
            if (line_b_out[0]) hib++;
            if (c > maxc) maxc = c;
            if (c < minc) minc = c;
            if (c != prev && c != prev + 1 && c != prev - 1 && !(c == 0 && prev == int'(cmp_c[0])))
                bad_step++;
            if (line_a_out[0] != (c >= 4 && c <= 7)) bad_rel++;
            prev = c;
            cyc(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0, c1, c2, c3, c4, c5, hia, hib, mx, mn, bs, br;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk(count == '0 && cap_ra == '0 && cap_rb == '0, "R1 counts/captures zero", int'(count[0]), 0);
        chk(ovf == '0 && ovr == '0 && ra_full == '0 && rb_full == '0, "R1 flags zero", int'(ovf), 0);
        chk(line_a_out == '0 && line_b_out == '0, "R1 lines zero", int'(line_a_out), 0);
        cyc(50);
        chk(count[0] == '0, "R1 stopped before trigger", int'(count[0]), 0);

        // R2: divider taps, table walked by one loop
        foreach (TBL[t]) begin
            sel_clk[0] = 3'(TBL[t][0]);
            pulse_trig(0);
            cyc(2);
            c0 = int'(count[0]);
            cyc(TBL[t][1]);
            c1 = int'(count[0]);
            chk(c1 - c0 == TBL[t][2], $sformatf("R2 tap code %0d", TBL[t][0]), c1 - c0, TBL[t][2]);
        end

        // R3: external clock pins
        sel_clk[0] = 3'd5;
        pulse_trig(0);
        ext_clk[0] = 1'b1; cyc(2);
        chk(count[0] == 0, "R3 no advance before sync latency", int'(count[0]), 0);
        cyc(1);
        chk(count[0] == 1, "R3 advance on third edge", int'(count[0]), 1);
        ext_clk[0] = 1'b0; ext_clk[1] = 1'b1; cyc(3); ext_clk[1] = 1'b0; cyc(5);
        chk(count[0] == 1, "R3 unselected pin ignored", int'(count[0]), 1);
        sel_clk[0] = 3'd6;
        ext_clk[1] = 1'b1; cyc(3); ext_clk[1] = 1'b0; cyc(2);
        chk(count[0] == 2, "R3 pin 1 selected", int'(count[0]), 2);

        // R4: global sync and per-channel trigger
        sel_clk = '0;
        glb_sync = 1'b1; cyc(1); glb_sync = 1'b0;
        cyc(40);
        chk(count[0] != 0 && count[1] != 0 && count[2] != 0, "R4 all running", int'(count[2]), 20);
        glb_sync = 1'b1; cyc(1); glb_sync = 1'b0;
        chk(count == '0, "R4 global sync clears all", int'(count[1]), 0);
        cyc(20);
        pulse_trig(1);
        chk(count[1] == 0 && count[0] >= 10, "R4 trigger is per channel", int'(count[0]), 10);

        // R5: overflow on channel 2
        pulse_trig(2);
        cyc(8000);
        chk(ovf[2] == 1'b0, "R5 no overflow before wrap", int'(ovf[2]), 0);
        cyc(400);
        chk(ovf[2] == 1'b1, "R5 overflow after wrap", int'(ovf[2]), 1);
        flag_clr[2] = 1'b1; cyc(1); flag_clr[2] = 1'b0;
        chk(ovf[2] == 1'b0, "R5 flag_clr clears", int'(ovf[2]), 0);

        // R6/R7/R8: capture on channel 0
        cap_edge[0] = 2'd0;
        pulse_trig(0);
        cyc(5);
        drive_line(1'b1, c1);
        chk(int'(cap_ra[0]) == c1 && ra_full[0] && !rb_full[0], "R6 R7 rising captures A", int'(cap_ra[0]), c1);
        cyc(5); drive_line(1'b0, c0);
        chk(!rb_full[0] && int'(cap_ra[0]) == c1, "R6 falling ignored", int'(rb_full[0]), 0);
        cyc(5); drive_line(1'b1, c2);
        chk(int'(cap_rb[0]) == c2 && rb_full[0] && c2 > c1, "R7 second capture into B", int'(cap_rb[0]), c2);
        cyc(3); drive_line(1'b0, c0); cyc(3); drive_line(1'b1, c3);
        chk(int'(cap_ra[0]) == c3 && ovr[0], "R8 overrun stores and flags", int'(cap_ra[0]), c3);
        rd_a[0] = 1'b1; rd_b[0] = 1'b1; cyc(1); rd_a[0] = 1'b0; rd_b[0] = 1'b0;
        chk(!ra_full[0] && !rb_full[0] && ovr[0], "R7 R8 reads clear full, overrun sticky", int'(ovr[0]), 1);
        flag_clr[0] = 1'b1; cyc(1); flag_clr[0] = 1'b0;
        chk(!ovr[0], "R8 flag_clr clears overrun", int'(ovr[0]), 0);
        cap_edge[0] = 2'd1;
        cyc(4); drive_line(1'b0, c4);
        chk(int'(cap_rb[0]) == c4 && rb_full[0], "R6 falling selected captures B", int'(cap_rb[0]), c4);
        cyc(4); drive_line(1'b1, c0);
        chk(!ra_full[0] && int'(cap_ra[0]) == c3, "R6 rising ignored in falling mode", int'(cap_ra[0]), c3);
        cap_edge[0] = 2'd2;
        cyc(4); drive_line(1'b0, c5);
        chk(int'(cap_ra[0]) == c5 && ra_full[0], "R6 both-edge mode captures fall", int'(cap_ra[0]), c5);

        // R12: capture mode holds lines low even with actions programmed
        act_am[0] = 2'd1; act_ca[0] = 2'd1; act_cb[0] = 2'd3; cmp_c[0] = 12'd3; cmp_a[0] = 12'd1;
        cyc(20);
        wave_window(64, hia, hib, mx, mn, bs, br);
        chk(hia == 0 && hib == 0, "R12 capture mode lines low", hia + hib, 0);

        // R9/R11: waveform up mode
        cmp_a[0] = 12'd3; cmp_c[0] = 12'd7; cmp_b[0] = 12'd0;
        act_am[0] = 2'd1; act_ca[0] = 2'd2; act_bm[0] = 2'd0; act_cb[0] = 2'd3;
        wave_mode[0] = 1'b1;
        pulse_trig(0);
        cyc(40);
        wave_window(128, hia, hib, mx, mn, bs, br);
        chk(mx == 7 && mn == 0 && bs == 0, "R9 up mode runs 0..C", mx, 7);
        chk(br == 0 && hia == 64, "R11 set at A, clear at C", hia, 64);
        chk(hib == 64, "R11 toggle B at C", hib, 64);

        // R11: coincident A and C, C action decides
        wave_mode[0] = 1'b0; cyc(2);
        cmp_a[0] = 12'd7; act_am[0] = 2'd3; act_ca[0] = 2'd1; act_cb[0] = 2'd0;
        wave_mode[0] = 1'b1;
        pulse_trig(0);
        cyc(20);
        wave_window(64, hia, hib, mx, mn, bs, br);
        chk(hia == 64, "R11 C action wins over A", hia, 64);

        // R10: up/down mode, toggle at A gives double-edge PWM
        wave_mode[0] = 1'b0; cyc(2);
        cmp_a[0] = 12'd2; cmp_c[0] = 12'd5; act_am[0] = 2'd3; act_ca[0] = 2'd0;
        updown[0] = 1'b1; wave_mode[0] = 1'b1;
        pulse_trig(0);
        cyc(60);
        wave_window(200, hia, hib, mx, mn, bs, br);
        chk(mx == 5 && mn == 0, "R10 turns at C and 0", mx, 5);
        chk(bs == 0, "R10 steps by one", bs, 0);
        chk(hia == 120, "R10 R11 up/down duty", hia, 120);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule